// File: doc/BRIEF.md
# Virtual UART Register Bridge

This block presents the register set of a classic 16550-style UART to a host over an 8-bit Wishbone slave port, with no serial shifter behind it. Instead of shifting bits onto a line, it moves bytes straight to and from FIFOs that sit outside it. A host read of the data register pops one byte from an external receive FIFO. A host write to the data register pushes one byte into an external transmit FIFO. Software written for a 16550 can therefore talk to another agent on the chip as if it were a serial port.

Line status comes from the FIFO flags. The transmitter is always reported as empty. A divisor latch pair is kept for software compatibility, but it drives nothing. One interrupt output covers two sources, received data and transmitter empty, each of which has its own enable bit. The interrupt identification register reports the highest-priority pending source.

Top module: `vuart_regbridge`

## Requirements
- R1: The line control (offset 3), modem control (offset 4), modem status (offset 6) and scratch (offset 7) registers are plain 8-bit storage. A read returns the last value written, and every register is zero after reset.
- R2: Offset 2 is the identification register on reads. Writes to offset 2 go to a write-only FIFO control register and do not change the value that offset 2 reads back.
- R3: Offset 5 reads 0x60 (bits 5 and 6 set) while `rx_avail` is low and 0x61 while `rx_avail` is high.
- R4: While bit 7 of the line control register is 1, offsets 0 and 1 read and write a divisor low byte and a divisor high byte. These are stored apart from the data path and from the interrupt enable register, and a read of offset 0 in this mode does not pop the receive FIFO. Clearing bit 7 brings back the normal mapping.
- R5: With bit 7 clear and `rx_avail` high, a read of offset 0 returns `rx_byte`. `rx_pop` goes high for exactly one clock, in the same cycle as the acknowledge.
- R6: With `rx_avail` low, a read of offset 0 returns 0x00 and `rx_pop` stays low.
- R7: With bit 7 clear, a write to offset 0 while `tx_space` is high raises `tx_push` for exactly one clock, in the acknowledge cycle, with `tx_byte` holding the written byte. While `tx_space` is low the write is dropped and `tx_push` stays low.
- R8: The interrupt enable register sits at offset 1. Bit 0 enables the received-data source, which is active while `rx_avail` is high. Bit 1 enables the transmit-empty source, which is always active.
- R9: The identification register reads 0x01 with nothing pending, 0x04 for received data and 0x02 for transmit empty. Received data wins when both sources are pending.
- R10: `irq` is high exactly when an enabled source is active. It follows a change of the enables or of `rx_avail` on the next rising clock edge.
- R11: Each request (`wb_cyc` and `wb_stb` high) is acknowledged on the following clock with a one-cycle `wb_ack`, and read data is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | 3 | Register offset |
| wb_dat_w | input | 8 | Write data |
| wb_dat_r | output | 8 | Read data, valid with ack |
| wb_ack | output | 1 | One-cycle acknowledge |
| rx_avail | input | 1 | Receive FIFO holds data |
| rx_byte | input | 8 | Head byte of receive FIFO |
| rx_pop | output | 1 | Receive FIFO read enable pulse |
| tx_space | input | 1 | Transmit FIFO can accept a byte |
| tx_push | output | 1 | Transmit FIFO write enable pulse |
| tx_byte | output | 8 | Byte for the transmit FIFO |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the one where the same two offsets mean different things depending on an earlier write. In that case a divisor access must neither pop the receive FIFO nor disturb the interrupt enables. The stimulus sets bank bit 7, fills both divisor bytes while `rx_avail` is high, reads them back and watches `rx_pop`. It then clears the bit and reads the enable register to show that it kept its old value. The interrupt priority case is reached by enabling both sources and then toggling `rx_avail` between identification reads.

// File: rtl/vuart_pkg.sv
package vuart_pkg;

    parameter int unsigned DW = 8;
    parameter int unsigned AW = 3;
    parameter int unsigned IDW = 4;
    localparam int unsigned BANK_BIT = 7;

    typedef enum logic [AW-1:0] {
        OFS_DATA    = 3'd0,
        OFS_IEN     = 3'd1,
        OFS_IDENT   = 3'd2,
        OFS_LCTL    = 3'd3,
        OFS_MCTL    = 3'd4,
        OFS_LSTAT   = 3'd5,
        OFS_MSTAT   = 3'd6,
        OFS_SCRATCH = 3'd7
    } ofs_e;

    localparam logic [IDW-1:0] ID_NONE = 4'b0001;
    localparam logic [IDW-1:0] ID_RXD  = 4'b0100;
    localparam logic [IDW-1:0] ID_TXE  = 4'b0010;

    localparam logic [DW-1:0] LSTAT_BASE = 8'h60;

    typedef struct packed {
        logic [DW-1:0] lctl;
        logic [DW-1:0] mctl;
        logic [DW-1:0] mstat;
        logic [DW-1:0] scratch;
        logic [DW-1:0] ien;
        logic [DW-1:0] div_lo;
        logic [DW-1:0] div_hi;
        logic [DW-1:0] rdata;
        logic [DW-1:0] txb;
        logic          ack;
        logic          pop;
        logic          push;
        logic          irq;
    } state_t;

    typedef struct packed {
        logic data;
        logic ien;
        logic lctl;
        logic mctl;
        logic mstat;
        logic scratch;
        logic div_lo;
        logic div_hi;
    } wsel_t;

endpackage

// File: rtl/vuart_decode.sv
module vuart_decode
    import vuart_pkg::*;
(
    input  logic          req_wr,
    input  logic [AW-1:0] adr,
    input  logic          bank,
    output wsel_t         wsel
);
    always_comb begin
        wsel = '0;
        if (req_wr) begin
            case (ofs_e'(adr))
                OFS_DATA:    if (bank) wsel.div_lo = 1'b1; else wsel.data = 1'b1;
                OFS_IEN:     if (bank) wsel.div_hi = 1'b1; else wsel.ien  = 1'b1;
                OFS_LCTL:    wsel.lctl    = 1'b1;
                OFS_MCTL:    wsel.mctl    = 1'b1;
                OFS_MSTAT:   wsel.mstat   = 1'b1;
                OFS_SCRATCH: wsel.scratch = 1'b1;
                default:     wsel = '0;
            endcase
        end
    end
endmodule

// File: rtl/vuart_irq_prio.sv
module vuart_irq_prio
    import vuart_pkg::*;
(
    input  logic           en_rx,
    input  logic           en_tx,
    input  logic           rx_avail,
    output logic           pending,
    output logic [IDW-1:0] ident
);
    logic rx_src;
    assign rx_src = en_rx & rx_avail;

    always_comb begin
        if (rx_src)      ident = ID_RXD;
        else if (en_tx)  ident = ID_TXE;
        else             ident = ID_NONE;
        pending = rx_src | en_tx;
    end
endmodule

// File: rtl/vuart_regbridge.sv
module vuart_regbridge
    import vuart_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wb_cyc,
    input  logic          wb_stb,
    input  logic          wb_we,
    input  logic [2:0]    wb_adr,
    input  logic [7:0]    wb_dat_w,
    output logic [7:0]    wb_dat_r,
    output logic          wb_ack,
    input  logic          rx_avail,
    input  logic [7:0]    rx_byte,
    output logic          rx_pop,
    input  logic          tx_space,
    output logic          tx_push,
    output logic [7:0]    tx_byte,
    output logic          irq
);
    state_t st_d, st_q;
    logic   req, bank, pending;
    logic [IDW-1:0] ident;
    wsel_t  wsel;

    assign req  = wb_cyc & wb_stb & ~st_q.ack;
    assign bank = st_q.lctl[BANK_BIT];

    vuart_decode u_dec (
        .req_wr (req & wb_we),
        .adr    (wb_adr),
        .bank   (bank),
        .wsel   (wsel)
    );

    vuart_irq_prio u_prio (
        .en_rx    (st_q.ien[0]),
        .en_tx    (st_q.ien[1]),
        .rx_avail (rx_avail),
        .pending  (pending),
        .ident    (ident)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ack  = req;
        st_d.pop  = 1'b0;
        st_d.push = 1'b0;
        st_d.irq  = pending;

        if (wsel.lctl)    st_d.lctl    = wb_dat_w;
        if (wsel.mctl)    st_d.mctl    = wb_dat_w;
        if (wsel.mstat)   st_d.mstat   = wb_dat_w;
        if (wsel.scratch) st_d.scratch = wb_dat_w;
        if (wsel.ien)     st_d.ien     = wb_dat_w;
        if (wsel.div_lo)  st_d.div_lo  = wb_dat_w;
        if (wsel.div_hi)  st_d.div_hi  = wb_dat_w;
        if (wsel.data && tx_space) begin
            st_d.push = 1'b1;
            st_d.txb  = wb_dat_w;
        end

        if (req && !wb_we) begin
            case (ofs_e'(wb_adr))
                OFS_DATA: begin
                    if (bank) begin
                        st_d.rdata = st_q.div_lo;
                    end else if (rx_avail) begin
                        st_d.rdata = rx_byte;
                        st_d.pop   = 1'b1;
                    end else begin
                        st_d.rdata = '0;
                    end
                end
                OFS_IEN:     st_d.rdata = bank ? st_q.div_hi : st_q.ien;
                OFS_IDENT:   st_d.rdata = {{(DW-IDW){1'b0}}, ident};
                OFS_LCTL:    st_d.rdata = st_q.lctl;
                OFS_MCTL:    st_d.rdata = st_q.mctl;
                OFS_LSTAT:   st_d.rdata = LSTAT_BASE | {{(DW-1){1'b0}}, rx_avail};
                OFS_MSTAT:   st_d.rdata = st_q.mstat;
                OFS_SCRATCH: st_d.rdata = st_q.scratch;
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_dat_r = st_q.rdata;
    assign wb_ack   = st_q.ack;
    assign rx_pop   = st_q.pop;
    assign tx_push  = st_q.push;
    assign tx_byte  = st_q.txb;
    assign irq      = st_q.irq;
endmodule

// File: rtl/vuart_regbridge_chk.sv
module vuart_regbridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wb_cyc,
    input logic       wb_stb,
    input logic       wb_we,
    input logic       wb_ack,
    input logic       rx_avail,
    input logic       rx_pop,
    input logic       tx_space,
    input logic       tx_push,
    input logic       irq,
    input logic [7:0] ien
);
    p_ack_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !wb_ack);

    p_ack_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> $past(wb_cyc && wb_stb));

    p_pop_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> !rx_pop);

    p_pop_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> ($past(rx_avail) && wb_ack && !$past(wb_we)));

    p_push_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |=> !tx_push);

    p_push_needs_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> ($past(tx_space) && wb_ack && $past(wb_we)));

    p_tx_src_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ien[1]) |-> irq);

    p_irq_has_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(ien[1])) |-> ($past(ien[0]) && $past(rx_avail)));
endmodule

bind vuart_regbridge vuart_regbridge_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_cyc   (wb_cyc),
    .wb_stb   (wb_stb),
    .wb_we    (wb_we),
    .wb_ack   (wb_ack),
    .rx_avail (rx_avail),
    .rx_pop   (rx_pop),
    .tx_space (tx_space),
    .tx_push  (tx_push),
    .irq      (irq),
    .ien      (st_q.ien)
);

// File: tb/vuart_regbridge_tb_top.sv
`timescale 1ns/1ps
module vuart_regbridge_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [2:0] wb_adr = '0;
    logic [7:0] wb_dat_w = '0;
    logic [7:0] wb_dat_r;
    logic       wb_ack;
    logic       rx_avail = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_pop;
    logic       tx_space = 1'b0;
    logic       tx_push;
    logic [7:0] tx_byte;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    logic seen_pop, seen_push, late_pop, late_push;
    logic [7:0] seen_txb;

    always #2.5 clk = ~clk;

    vuart_regbridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
        .rx_avail(rx_avail), .rx_byte(rx_byte), .rx_pop(rx_pop),
        .tx_space(tx_space), .tx_push(tx_push), .tx_byte(tx_byte), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read data from the scoreboard on each read ack
    always @(negedge clk) begin
        if (wb_ack && !wb_we) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected read ack", 8'h1, 8'h0);
            end else begin
                check(tag_q.pop_front(), wb_dat_r, exp_q.pop_front());
            end
        end
    end

    task automatic access(input logic we, input logic [2:0] adr, input logic [7:0] dat);
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = adr; wb_dat_w = dat;
        @(posedge clk);
        @(negedge clk); #1;
        check("R11 ack after one clock", {7'd0, wb_ack}, 8'h1);
        seen_pop = rx_pop; seen_push = tx_push; seen_txb = tx_byte;
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
        @(posedge clk);
        @(negedge clk); #1;
        check("R11 ack single cycle", {7'd0, wb_ack}, 8'h0);
        late_pop = rx_pop; late_push = tx_push;
    endtask

    task automatic wr(input logic [2:0] adr, input logic [7:0] dat);
        access(1'b1, adr, dat);
    endtask

    task automatic rd(input logic [2:0] adr, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b0, adr, 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R11 reset ack", {7'd0, wb_ack}, 8'h0);
        check("R10 reset irq", {7'd0, irq}, 8'h0);
        check("R5 reset pop", {7'd0, rx_pop}, 8'h0);
        check("R7 reset push", {7'd0, tx_push}, 8'h0);
        rd(3'd7, 8'h00, "R1 scratch reset");

        // R1 storage registers
        wr(3'd3, 8'h0F); wr(3'd4, 8'h10); wr(3'd6, 8'h11); wr(3'd7, 8'h12);
        rd(3'd3, 8'h0F, "R1 lctl"); rd(3'd4, 8'h10, "R1 mctl");
        rd(3'd6, 8'h11, "R1 mstat"); rd(3'd7, 8'h12, "R1 scratch");

        // R2 FIFO control write leaves identification intact
        rd(3'd2, 8'h01, "R2 ident before");
        wr(3'd2, 8'hC7);
        rd(3'd2, 8'h01, "R2 ident after fcr write");

        // R3 line status
        rd(3'd5, 8'h60, "R3 lstat empty");
        rx_avail = 1'b1; rx_byte = 8'h99;
        rd(3'd5, 8'h61, "R3 lstat ready");
        check("R3 lstat read no pop", {7'd0, seen_pop}, 8'h0);

        // R4 divisor bank
        wr(3'd3, 8'h80);
        wr(3'd0, 8'h5A);
        check("R4 divisor write no push", {7'd0, seen_push}, 8'h0);
        wr(3'd1, 8'hA5);
        rd(3'd0, 8'h5A, "R4 div lo");
        check("R4 divisor read no pop", {7'd0, seen_pop}, 8'h0);
        rd(3'd1, 8'hA5, "R4 div hi");
        check("R8 irq off while bank write", {7'd0, irq}, 8'h0);
        wr(3'd3, 8'h00);
        rd(3'd1, 8'h00, "R4 ien untouched");

        // R5 receive pop
        rx_byte = 8'h45;
        rd(3'd0, 8'h45, "R5 rx data");
        check("R5 pop in ack cycle", {7'd0, seen_pop}, 8'h1);
        check("R5 pop one cycle", {7'd0, late_pop}, 8'h0);

        // R6 empty read
        rx_avail = 1'b0; rx_byte = 8'h33;
        rd(3'd0, 8'h00, "R6 empty read");
        check("R6 no pop", {7'd0, seen_pop | late_pop}, 8'h0);

        // R7 transmit push
        tx_space = 1'b1;
        wr(3'd0, 8'h65);
        check("R7 push in ack cycle", {7'd0, seen_push}, 8'h1);
        check("R7 tx byte", seen_txb, 8'h65);
        check("R7 push one cycle", {7'd0, late_push}, 8'h0);
        tx_space = 1'b0;
        wr(3'd0, 8'h77);
        check("R7 full drop", {7'd0, seen_push | late_push}, 8'h0);
        check("R7 tx byte held", tx_byte, 8'h65);

        // R8/R9/R10 interrupts
        wr(3'd1, 8'h00);
        rx_avail = 1'b1; rx_byte = 8'h45;
        @(negedge clk); #1;
        check("R8 no irq when disabled", {7'd0, irq}, 8'h0);
        rd(3'd2, 8'h01, "R9 ident none");
        wr(3'd1, 8'h01);
        check("R8 rx irq", {7'd0, irq}, 8'h1);
        rd(3'd2, 8'h04, "R9 ident rx");
        @(negedge clk);
        rx_avail = 1'b0;
        #1;
        check("R10 irq holds before edge", {7'd0, irq}, 8'h1);
        @(negedge clk); #1;
        check("R10 irq drops after edge", {7'd0, irq}, 8'h0);
        rd(3'd2, 8'h01, "R9 ident none again");
        wr(3'd1, 8'h02);
        check("R8 tx irq", {7'd0, irq}, 8'h1);
        rd(3'd2, 8'h02, "R9 ident tx");
        wr(3'd1, 8'h03);
        rx_avail = 1'b1;
        @(negedge clk); #1;
        check("R8 both irq", {7'd0, irq}, 8'h1);
        rd(3'd2, 8'h04, "R9 rx over tx priority");
        rd(3'd1, 8'h03, "R8 ien readback");

        repeat (2) @(negedge clk);
        check("R11 scoreboard drained", 8'(exp_q.size()), 8'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule